// File: doc/BRIEF.md
# Counter Channel Byte Register Interface

This block connects an 8-bit host bus to one position counter channel. The host sees two ports, chosen by a select line. The data port carries the multi-byte preset value (on write) and the multi-byte latched count (on read). The control port accepts single command bytes (on write) and returns a flag byte (on read). The counter core and the quadrature decoder sit outside this block. The block holds the preset, the count snapshot and the configuration fields, and gives the core its strobes.

A command byte is split by its three top bits. The group `000` holds exact-match action codes: reset the byte pointers, transfer the preset into the counter, snapshot the counter, and clear the flags. The groups `001`, `010` and `011` load a small configuration register from the low bits of the byte. The preset and the snapshot are each reached through their own byte pointer. Each pointer steps on every data-port access of its direction and wraps after the last byte.

Top module: `qcnt_host_if`

## Requirements
- R1: After reset, `preset_o` is 0, every configuration output is 0, every strobe is 0, `host_rdata` is 0, and both byte pointers are at byte 0.
- R2: A data-port write stores `host_wdata` into the preset byte chosen by the write pointer (byte 0 = bits 7:0), then advances the pointer, which wraps from byte 2 to byte 0.
- R3: Control byte 0x01 returns both the write pointer and the read pointer to byte 0.
- R4: Control byte 0x08 drives `xfer_o` high for exactly the one cycle after the write.
- R5: Control byte 0x11 copies `cnt_i` into the snapshot and returns both pointers to byte 0. Each data-port read then loads `host_rdata` in the next cycle with the snapshot byte at the read pointer (least significant first, wrapping from byte 2 to byte 0). The snapshot does not change until the next 0x11.
- R6: Control byte 0x02 pulses `clr_flags_o` for one cycle, and control byte 0x06 pulses `clr_err_o` for one cycle.
- R7: A control byte with top bits `001` sets `count_mode_o` from bits [2:1] and `quad_scale_o` from bits [4:3].
- R8: A control byte with top bits `010` sets `ab_en_o` from bit 0 and `idx_preset_o` from bit 1.
- R9: A control byte with top bits `011` sets `idx_sync_o` from bit 0 and `idx_pol_o` from bit 1.
- R10: A control-port read loads `host_rdata` in the next cycle with borrow in bit 0, carry in bit 1, noise error in bit 4 and count-up direction in bit 5. All other bits are 0.
- R11: Any other control byte is ignored: no strobe, no change to the configuration, the preset, the snapshot or either pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_ctl | input | 1 | 1 selects the control port, 0 the data port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid the cycle after a read |
| cnt_i | input | 24 | Current counter value |
| borrow_i | input | 1 | Borrow flag from the counter |
| carry_i | input | 1 | Carry flag from the counter |
| noise_i | input | 1 | Noise error flag from the decoder |
| dir_up_i | input | 1 | Counting direction, 1 = up |
| preset_o | output | 24 | Preset value |
| xfer_o | output | 1 | Load-preset-into-counter strobe |
| clr_flags_o | output | 1 | Clear borrow/carry/compare/sign strobe |
| clr_err_o | output | 1 | Clear error flag strobe |
| count_mode_o | output | 2 | Count mode |
| quad_scale_o | output | 2 | Quadrature scale code |
| ab_en_o | output | 1 | Count input enable |
| idx_preset_o | output | 1 | Preset on index enable |
| idx_sync_o | output | 1 | Index synchronous mode |
| idx_pol_o | output | 1 | Index polarity |

## Verification
Directed sequences cover four cases:
- Preset writes that run past the third byte, which shows that the pointer wraps rather than sticks.
- Snapshot reads taken while the live count keeps moving, which tells a held snapshot apart from a pass-through.
- Flag patterns with single bits set, which expose swapped bit positions.
- Undefined codes next to valid ones (0x00, 0x1F, 0x80, 0xFF), which show that decoding needs an exact match rather than a partial one.

A seeded random mix then interleaves data writes, data reads, flag reads, counter changes and arbitrary control bytes. This exercises the interaction between the two independent pointers and pointer resets that arrive partway through a multi-byte access.

// File: rtl/qcnt_pkg.sv
package qcnt_pkg;
   // action codes in the 000 group (exact match)
   localparam logic [7:0] CMD_PTR_RST   = 8'h01;
   localparam logic [7:0] CMD_CLR_FLAGS = 8'h02;
   localparam logic [7:0] CMD_CLR_ERR   = 8'h06;
   localparam logic [7:0] CMD_XFER      = 8'h08;
   localparam logic [7:0] CMD_LATCH     = 8'h11;

   // group select in bits [7:5]
   localparam logic [2:0] GRP_ACT  = 3'b000;
   localparam logic [2:0] GRP_MODE = 3'b001;
   localparam logic [2:0] GRP_IOC  = 3'b010;
   localparam logic [2:0] GRP_IDX  = 3'b011;

   typedef struct packed {
      logic ptr_rst;
      logic latch;
      logic xfer;
      logic clr_flags;
      logic clr_err;
      logic ld_mode;
      logic ld_ioc;
      logic ld_idx;
   } cmd_t;
endpackage

// File: rtl/qcnt_cmd_dec.sv
module qcnt_cmd_dec
   import qcnt_pkg::*;
(
   input  logic       valid,
   input  logic [7:0] code,
   output cmd_t       cmd
);
   always_comb begin
      cmd = '0;
      if (valid) begin
         case (code[7:5])
            GRP_ACT: begin
               case (code)
                  CMD_PTR_RST:   cmd.ptr_rst   = 1'b1;
                  CMD_LATCH:     begin
                     cmd.ptr_rst = 1'b1;
                     cmd.latch   = 1'b1;
                  end
                  CMD_XFER:      cmd.xfer      = 1'b1;
                  CMD_CLR_FLAGS: cmd.clr_flags = 1'b1;
                  CMD_CLR_ERR:   cmd.clr_err   = 1'b1;
                  default: ;
               endcase
            end
            GRP_MODE: cmd.ld_mode = 1'b1;
            GRP_IOC:  cmd.ld_ioc  = 1'b1;
            GRP_IDX:  cmd.ld_idx  = 1'b1;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/qcnt_byte_ptr.sv
module qcnt_byte_ptr #(
   parameter int NBYTES = 3,
   localparam int PW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          step,
   output logic [PW-1:0] ptr
);
   localparam logic [PW-1:0] LAST = PW'(NBYTES - 1);

   always_ff @(posedge clk) begin
      if (!rst_n)         ptr <= '0;
      else if (clr)       ptr <= '0;
      else if (step)      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
   end

   // R2/R5: the pointer wraps after the last byte
   a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && ptr == LAST) |=> (ptr == '0));
   // R3: a reset command returns the pointer to byte 0
   a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (ptr == '0));
   a_r2_range: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr <= LAST));
endmodule

// File: rtl/qcnt_preset_reg.sv
module qcnt_preset_reg #(
   parameter int DW     = 8,
   parameter int NBYTES = 3,
   localparam int PW = (NBYTES > 1) ? $clog2(NBYTES) : 1,
   localparam int CW = DW * NBYTES
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [PW-1:0] sel,
   input  logic [DW-1:0] din,
   output logic [CW-1:0] q
);
   for (genvar gi = 0; gi < NBYTES; gi++) begin : g_lane
      logic [DW-1:0] lane_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                          lane_q <= '0;
         else if (we && sel == PW'(gi))       lane_q <= din;
      end
      assign q[gi*DW +: DW] = lane_q;
   end

   // R2: the preset only moves on a data-port write
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));
endmodule

// File: rtl/qcnt_host_if.sv
module qcnt_host_if
   import qcnt_pkg::*;
#(
   parameter int DW     = 8,
   parameter int NBYTES = 3,
   localparam int CW = DW * NBYTES,
   localparam int PW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_wr,
   input  logic          host_rd,
   input  logic          host_ctl,
   input  logic [DW-1:0] host_wdata,
   output logic [DW-1:0] host_rdata,
   input  logic [CW-1:0] cnt_i,
   input  logic          borrow_i,
   input  logic          carry_i,
   input  logic          noise_i,
   input  logic          dir_up_i,
   output logic [CW-1:0] preset_o,
   output logic          xfer_o,
   output logic          clr_flags_o,
   output logic          clr_err_o,
   output logic [1:0]    count_mode_o,
   output logic [1:0]    quad_scale_o,
   output logic          ab_en_o,
   output logic          idx_preset_o,
   output logic          idx_sync_o,
   output logic          idx_pol_o
);
   if (DW != 8) begin : g_bad_dw
      $error("qcnt_host_if: command codes are byte codes, DW must be 8");
   end
   if (NBYTES < 1) begin : g_bad_nb
      $error("qcnt_host_if: NBYTES must be at least 1");
   end

   cmd_t          cmd;
   logic [PW-1:0] wp, rp;
   logic [CW-1:0] latch_q;
   logic [DW-1:0] lat_b [NBYTES];
   logic [DW-1:0] flag_b;
   logic [3:0]    mode_q;
   logic [1:0]    ioc_q, idx_q;
   logic          xfer_q, clrf_q, clre_q;

   wire ctl_wr  = host_wr &&  host_ctl;
   wire dat_wr  = host_wr && !host_ctl;
   wire dat_rd  = host_rd && !host_ctl;

   qcnt_cmd_dec u_dec (
      .valid (ctl_wr),
      .code  (host_wdata[7:0]),
      .cmd   (cmd)
   );

   qcnt_byte_ptr #(.NBYTES(NBYTES)) u_wptr (
      .clk (clk), .rst_n (rst_n), .clr (cmd.ptr_rst), .step (dat_wr), .ptr (wp)
   );

   qcnt_byte_ptr #(.NBYTES(NBYTES)) u_rptr (
      .clk (clk), .rst_n (rst_n), .clr (cmd.ptr_rst), .step (dat_rd), .ptr (rp)
   );

   qcnt_preset_reg #(.DW(DW), .NBYTES(NBYTES)) u_preset (
      .clk (clk), .rst_n (rst_n), .we (dat_wr), .sel (wp),
      .din (host_wdata), .q (preset_o)
   );

   // count snapshot
   always_ff @(posedge clk) begin
      if (!rst_n)         latch_q <= '0;
      else if (cmd.latch) latch_q <= cnt_i;
   end

   for (genvar gi = 0; gi < NBYTES; gi++) begin : g_lat
      assign lat_b[gi] = latch_q[gi*DW +: DW];
   end

   always_comb begin
      flag_b    = '0;
      flag_b[0] = borrow_i;
      flag_b[1] = carry_i;
      flag_b[4] = noise_i;
      flag_b[5] = dir_up_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       host_rdata <= '0;
      else if (host_rd) host_rdata <= host_ctl ? flag_b : lat_b[rp];
   end

   // configuration registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
         ioc_q  <= '0;
         idx_q  <= '0;
      end else begin
         if (cmd.ld_mode) mode_q <= host_wdata[4:1];
         if (cmd.ld_ioc)  ioc_q  <= host_wdata[1:0];
         if (cmd.ld_idx)  idx_q  <= host_wdata[1:0];
      end
   end

   // one-cycle strobes
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xfer_q <= 1'b0;
         clrf_q <= 1'b0;
         clre_q <= 1'b0;
      end else begin
         xfer_q <= cmd.xfer;
         clrf_q <= cmd.clr_flags;
         clre_q <= cmd.clr_err;
      end
   end

   assign xfer_o       = xfer_q;
   assign clr_flags_o  = clrf_q;
   assign clr_err_o    = clre_q;
   assign count_mode_o = mode_q[1:0];
   assign quad_scale_o = mode_q[3:2];
   assign ab_en_o      = ioc_q[0];
   assign idx_preset_o = ioc_q[1];
   assign idx_sync_o   = idx_q[0];
   assign idx_pol_o    = idx_q[1];

   // R4: a transfer strobe follows a 0x08 write on the control port
   a_r4_xfer_src: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_o |-> $past(host_wr && host_ctl && host_wdata == CMD_XFER));
   // R5: the snapshot holds unless a latch command arrives
   a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_wr && host_ctl && host_wdata == CMD_LATCH) |=> $stable(latch_q));
   // R6: strobes never overlap
   a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({xfer_o, clr_flags_o, clr_err_o}));
   // R11: codes with the top bit set change nothing
   a_r11_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_ctl && host_wdata[7]) |=>
         ($stable({mode_q, ioc_q, idx_q, wp, rp}) && !xfer_o && !clr_flags_o && !clr_err_o));
endmodule

// File: tb/qcnt_host_if_test.sv
`timescale 1ns/1ps
module qcnt_host_if_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0, host_rd = 1'b0, host_ctl = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic [23:0] cnt_i = '0;
   logic        borrow_i = 1'b0, carry_i = 1'b0, noise_i = 1'b0, dir_up_i = 1'b0;
   logic [23:0] preset_o;
   logic        xfer_o, clr_flags_o, clr_err_o;
   logic [1:0]  count_mode_o, quad_scale_o;
   logic        ab_en_o, idx_preset_o, idx_sync_o, idx_pol_o;

   always #4 clk = ~clk;

   qcnt_host_if uut (
      .clk, .rst_n, .host_wr, .host_rd, .host_ctl, .host_wdata, .host_rdata,
      .cnt_i, .borrow_i, .carry_i, .noise_i, .dir_up_i, .preset_o,
      .xfer_o, .clr_flags_o, .clr_err_o, .count_mode_o, .quad_scale_o,
      .ab_en_o, .idx_preset_o, .idx_sync_o, .idx_pol_o
   );

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   // reference state
   logic [23:0] m_preset = '0, m_latch = '0;
   int          m_wp = 0, m_rp = 0;
   logic [1:0]  m_cm = '0, m_qs = '0;
   logic        m_ab = 0, m_pi = 0, m_sy = 0, m_po = 0;
   logic        e_xfer = 0, e_cf = 0, e_ce = 0;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_flags();
      return {2'b00, dir_up_i, noise_i, 2'b00, carry_i, borrow_i};
   endfunction

   function automatic int nxt(int p);
      return (p == 2) ? 0 : p + 1;
   endfunction

   task automatic check_state();
      chk("R2 preset", preset_o, m_preset);
      chk("R7 mode fields", {count_mode_o, quad_scale_o}, {m_cm, m_qs});
      chk("R8 io control", {ab_en_o, idx_preset_o}, {m_ab, m_pi});
      chk("R9 index control", {idx_sync_o, idx_pol_o}, {m_sy, m_po});
      chk("R4/R6/R11 strobes", {xfer_o, clr_flags_o, clr_err_o}, {e_xfer, e_cf, e_ce});
   endtask

   task automatic model_ctl(logic [7:0] d);
      e_xfer = 0; e_cf = 0; e_ce = 0;
      case (d[7:5])
         3'b000: case (d)
            8'h01: begin m_wp = 0; m_rp = 0; end
            8'h11: begin m_wp = 0; m_rp = 0; m_latch = cnt_i; end
            8'h08: e_xfer = 1;
            8'h02: e_cf = 1;
            8'h06: e_ce = 1;
            default: ;
         endcase
         3'b001: begin m_cm = d[2:1]; m_qs = d[4:3]; end
         3'b010: begin m_ab = d[0]; m_pi = d[1]; end
         3'b011: begin m_sy = d[0]; m_po = d[1]; end
         default: ;
      endcase
   endtask

   task automatic wr(bit ctl, logic [7:0] d);
      if (ctl) model_ctl(d);
      else begin
         e_xfer = 0; e_cf = 0; e_ce = 0;
         m_preset[8*m_wp +: 8] = d;
         m_wp = nxt(m_wp);
      end
      @(negedge clk);
      host_wr = 1; host_ctl = ctl; host_wdata = d;
      @(negedge clk);
      host_wr = 0;
      check_state();
   endtask

   task automatic rd(bit ctl);
      logic [7:0] e;
      e_xfer = 0; e_cf = 0; e_ce = 0;
      if (ctl) e = exp_flags();
      else begin
         e = m_latch[8*m_rp +: 8];
         m_rp = nxt(m_rp);
      end
      @(negedge clk);
      host_rd = 1; host_ctl = ctl;
      @(negedge clk);
      host_rd = 0;
      chk(ctl ? "R10 flag byte" : "R5 snapshot byte", host_rdata, e);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 reset preset", preset_o, 24'h0);
      chk("R1 reset config", {count_mode_o, quad_scale_o, ab_en_o, idx_preset_o, idx_sync_o, idx_pol_o}, 0);
      chk("R1 reset strobes", {xfer_o, clr_flags_o, clr_err_o}, 0);
      chk("R1 reset rdata", host_rdata, 0);

      // R2 byte order and wrap
      wr(0, 8'h56); wr(0, 8'h34); wr(0, 8'h12);
      chk("R2 assembled", preset_o, 24'h123456);
      wr(0, 8'h9A);
      chk("R2 wrap to byte0", preset_o, 24'h12349A);
      // R3 pointer reset mid-sequence
      wr(0, 8'hBC);
      wr(1, 8'h01);
      wr(0, 8'h77);
      chk("R3 pointer reset", preset_o, 24'h12BC77);

      // R5 snapshot, held while count moves, wrap
      cnt_i = 24'hABCDEF;
      wr(1, 8'h11);
      cnt_i = 24'h000111;
      rd(0); rd(0); rd(0); rd(0);
      wr(1, 8'h01);
      rd(0);

      // R4 / R6 strobes
      wr(1, 8'h08);
      wr(1, 8'h02);
      wr(1, 8'h06);

      // R7 R8 R9 field loads
      wr(1, 8'h20 | 8'h1E);
      wr(1, 8'h20 | 8'h0A);
      wr(1, 8'h40 | 8'h03);
      wr(1, 8'h40 | 8'h02);
      wr(1, 8'h60 | 8'h01);
      wr(1, 8'h60 | 8'h02);

      // R10 single-bit flag patterns
      borrow_i = 1; rd(1); borrow_i = 0;
      carry_i = 1;  rd(1); carry_i = 0;
      noise_i = 1;  rd(1); noise_i = 0;
      dir_up_i = 1; rd(1);

      // R11 undefined codes next to valid ones; pointers must not move
      wr(0, 8'h42);
      wr(1, 8'h00); wr(1, 8'h1F); wr(1, 8'h80); wr(1, 8'hFF); wr(1, 8'h09);
      wr(0, 8'h43);
      chk("R11 pointer untouched", preset_o, m_preset);
      rd(0);

      // random mix
      for (int i = 0; i < 1500; i++) begin
         int op;
         op = $urandom % 8;
         case (op)
            0, 1: wr(0, 8'($urandom));
            2, 3: rd(0);
            4: begin
               {borrow_i, carry_i, noise_i, dir_up_i} = 4'($urandom);
               rd(1);
            end
            5: begin
               logic [7:0] c;
               case ($urandom % 8)
                  0: c = 8'h01;
                  1: c = 8'h08;
                  2: c = 8'h11;
                  3: c = 8'h02;
                  4: c = 8'h06;
                  5: c = 8'h20 | 8'($urandom % 32);
                  6: c = 8'h40 | 8'($urandom % 4);
                  default: c = 8'h60 | 8'($urandom % 4);
               endcase
               wr(1, c);
            end
            6: wr(1, 8'($urandom));
            default: begin
               @(negedge clk);
               cnt_i = 24'($urandom);
            end
         endcase
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule